// File: doc/BRIEF.md
# Programmable Raster Timing and Pixel Output Generator

This block produces the raster timing for a 16-bit YCbCr 4:2:2 video link. It drives horizontal sync, vertical sync, a data-enable strobe and the pixel bus, all timed by an externally supplied pixel clock. A horizontal counter steps once per pixel clock and wraps at a programmable line length. A vertical counter steps once per line and wraps at a programmable line count. Every raster position counts from the first clock of the sync pulse, so the programmed active-start and active-end positions already include the sync width and the back porch. Out of reset the timing holds 1080p values: 2200 clocks per line, a 44-clock line sync, horizontal active from 192 up to but not including 2112, 1125 lines per frame, a 5-line frame sync, and vertical active from line 41 up to but not including line 1121.

Pixels come from an upstream stream source. The block raises a request strobe in each cycle in which it consumes a pixel. A solid-colour test mode can replace the stream with a colour taken from a register input. The output enable and the test-mode enable act on a low-to-high change of their control bits. A low control bit turns the function off at the next clock. The timing inputs are copied into shadow registers when output starts and at each frame boundary, so a frame is never drawn with mixed timing.

Top module: `raster_video_gen`

## Requirements
- R1: While reset is asserted and just after it is released, hsync, vsync, data-enable, the request strobe and the pixel bus are all 0.
- R2: While running, the horizontal position counts 0,1,...,H_total-1 and then returns to 0. Hsync is 1 exactly when the horizontal position is below the programmed hsync width (a width of 0 gives no pulse).
- R3: The horizontal active window covers the positions p with h_act_start <= p < h_act_end.
- R4: The vertical position advances by one when the horizontal position wraps, and returns to 0 after line V_total-1. Vsync is 1 exactly when the line number is below the programmed vsync width.
- R5: Data-enable is 1 exactly when the horizontal window holds and the line l satisfies v_act_start <= l < v_act_end.
- R6: Output starts only at a clock edge where the output-enable bit is 1 and was 0 at the previous edge. The raster then begins at position (0,0) in the next cycle. A bit held at 1 through reset does not start output. While the bit is 0 the block is idle at the next clock, with all outputs at 0.
- R7: The test mode turns on at a 0-to-1 change of its bit and off when the bit is 0. While it is on, every active pixel carries the colour input and the request strobe stays 0.
- R8: With the test mode off, the request strobe equals data-enable and the pixel bus carries the stream data input while data-enable is 1.
- R9: The pixel bus is 0 whenever data-enable is 0.
- R10: Timing inputs changed while the raster runs have no effect until the frame boundary after the last clock of line V_total-1. The new values then apply from position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_h_total | input | CNT_W | Clocks per line |
| cfg_h_sync | input | CNT_W | Hsync width in clocks |
| cfg_h_act_start | input | CNT_W | First active horizontal position |
| cfg_h_act_end | input | CNT_W | Horizontal position just after the active region |
| cfg_v_total | input | CNT_W | Lines per frame |
| cfg_v_sync | input | CNT_W | Vsync width in lines |
| cfg_v_act_start | input | CNT_W | First active line |
| cfg_v_act_end | input | CNT_W | Line just after the active region |
| cfg_out_en | input | 1 | Output enable; rising change starts the raster |
| cfg_pat_en | input | 1 | Test colour enable; rising change turns it on |
| cfg_pat_color | input | PIX_W | Test colour value |
| s_pix_data | input | PIX_W | Upstream pixel data |
| s_pix_ready | output | 1 | Pixel consumed this cycle |
| vid_hsync | output | 1 | Horizontal sync |
| vid_vsync | output | 1 | Vertical sync |
| vid_de | output | 1 | Data enable |
| vid_data | output | PIX_W | Pixel bus |

## Verification
The bench targets the frame-boundary handoff of timing values by changing every timing input in the middle of a frame. A design that loaded the shadows early would wrap lines at the wrong length part-way through a frame. It holds output-enable high through reset. An edge detector primed to 0 would then start the raster without a request. A degenerate setup with zero sync widths and windows that cover the whole line and frame checks the window bounds. An off-by-one compare there would clip the last active pixel or add a stray sync pulse. Random toggling of the test mode checks that the request strobe drops with it. A design that left the strobe on would drain stream pixels that are never shown.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int POS_W = 16;
  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    pos_t h_total;
    pos_t h_sync;
    pos_t h_act_start;
    pos_t h_act_end;
    pos_t v_total;
    pos_t v_sync;
    pos_t v_act_start;
    pos_t v_act_end;
  } timing_t;

  // half-open window test: lo <= p < hi
  function automatic logic in_window(pos_t p, pos_t lo, pos_t hi);
    return (p >= lo) && (p < hi);
  endfunction

  // sync pulse occupies positions below its width
  function automatic logic below(pos_t p, pos_t width);
    return p < width;
  endfunction

  // last position of a span of 'total' (degenerate totals wrap every step)
  function automatic logic at_last(pos_t p, pos_t total);
    return ({1'b0, p} + 17'd1) >= {1'b0, total};
  endfunction

  function automatic pos_t step_wrap(pos_t p, logic last);
    return last ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/raster_arm.sv
module raster_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic armed,
  output logic rise
);
  logic level_q;

  // level_q resets to 1 so a bit already high at reset is not a rising change
  assign rise = level & ~level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      armed   <= 1'b0;
    end else begin
      level_q <= level;
      if (!level)
        armed <= 1'b0;
      else if (rise)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/raster_shadow.sv
module raster_shadow #(
  parameter raster_pkg::timing_t RESET_TIM = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  raster_pkg::timing_t cfg_tim,
  output raster_pkg::timing_t tim
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      tim <= RESET_TIM;
    else if (load)
      tim <= cfg_tim;
  end
endmodule

// File: rtl/raster_counter.sv
module raster_counter (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  raster_pkg::pos_t h_total,
  input  raster_pkg::pos_t v_total,
  output raster_pkg::pos_t h_pos,
  output raster_pkg::pos_t v_pos,
  output logic             line_end,
  output logic             frame_end
);
  import raster_pkg::*;

  assign line_end  = at_last(h_pos, h_total);
  assign frame_end = line_end && at_last(v_pos, v_total);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (run) begin
      h_pos <= step_wrap(h_pos, line_end);
      if (line_end)
        v_pos <= step_wrap(v_pos, frame_end);
    end
  end
endmodule

// File: rtl/raster_pixel.sv
module raster_pixel #(
  parameter int PIX_W = 16
) (
  input  logic             run,
  input  logic             pat_on,
  input  raster_pkg::pos_t h_pos,
  input  raster_pkg::pos_t v_pos,
  input  raster_pkg::pos_t h_sync,
  input  raster_pkg::pos_t h_act_start,
  input  raster_pkg::pos_t h_act_end,
  input  raster_pkg::pos_t v_sync,
  input  raster_pkg::pos_t v_act_start,
  input  raster_pkg::pos_t v_act_end,
  input  logic [PIX_W-1:0] pat_color,
  input  logic [PIX_W-1:0] s_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             ready,
  output logic [PIX_W-1:0] data
);
  import raster_pkg::*;

  logic h_win, v_win;

  assign h_win = in_window(h_pos, h_act_start, h_act_end);
  assign v_win = in_window(v_pos, v_act_start, v_act_end);

  always_comb begin
    hsync = run && below(h_pos, h_sync);
    vsync = run && below(v_pos, v_sync);
    de    = run && h_win && v_win;
    ready = de && !pat_on;
    if (!de)
      data = '0;
    else if (pat_on)
      data = pat_color;
    else
      data = s_data;
  end
endmodule

// File: rtl/raster_video_gen.sv
module raster_video_gen #(
  parameter int CNT_W        = 12,
  parameter int PIX_W        = 16,
  parameter int DEF_H_TOTAL  = 2200,
  parameter int DEF_H_SYNC   = 44,
  parameter int DEF_H_START  = 192,
  parameter int DEF_H_END    = 2112,
  parameter int DEF_V_TOTAL  = 1125,
  parameter int DEF_V_SYNC   = 5,
  parameter int DEF_V_START  = 41,
  parameter int DEF_V_END    = 1121
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_h_total,
  input  logic [CNT_W-1:0] cfg_h_sync,
  input  logic [CNT_W-1:0] cfg_h_act_start,
  input  logic [CNT_W-1:0] cfg_h_act_end,
  input  logic [CNT_W-1:0] cfg_v_total,
  input  logic [CNT_W-1:0] cfg_v_sync,
  input  logic [CNT_W-1:0] cfg_v_act_start,
  input  logic [CNT_W-1:0] cfg_v_act_end,
  input  logic             cfg_out_en,
  input  logic             cfg_pat_en,
  input  logic [PIX_W-1:0] cfg_pat_color,
  input  logic [PIX_W-1:0] s_pix_data,
  output logic             s_pix_ready,
  output logic             vid_hsync,
  output logic             vid_vsync,
  output logic             vid_de,
  output logic [PIX_W-1:0] vid_data
);
  import raster_pkg::*;

  localparam int N_CTL = 2;
  localparam int CTL_OUT = 0;
  localparam int CTL_PAT = 1;
  localparam timing_t DEF_TIM = '{
    h_total:     pos_t'(DEF_H_TOTAL),
    h_sync:      pos_t'(DEF_H_SYNC),
    h_act_start: pos_t'(DEF_H_START),
    h_act_end:   pos_t'(DEF_H_END),
    v_total:     pos_t'(DEF_V_TOTAL),
    v_sync:      pos_t'(DEF_V_SYNC),
    v_act_start: pos_t'(DEF_V_START),
    v_act_end:   pos_t'(DEF_V_END)
  };

  // named internal events, visible to the bound checker
  logic [N_CTL-1:0] ctl_level, ctl_armed, ctl_rise;
  logic    run, pat_on, out_rise, counter_clear, shadow_load;
  logic    line_end, frame_end;
  pos_t    h_pos, v_pos;
  timing_t cfg_tim, tim_sh;

  assign ctl_level[CTL_OUT] = cfg_out_en;
  assign ctl_level[CTL_PAT] = cfg_pat_en;

  for (genvar g = 0; g < N_CTL; g++) begin : g_arm
    raster_arm u_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .level (ctl_level[g]),
      .armed (ctl_armed[g]),
      .rise  (ctl_rise[g])
    );
  end

  assign run           = ctl_armed[CTL_OUT];
  assign pat_on        = ctl_armed[CTL_PAT];
  assign out_rise      = ctl_rise[CTL_OUT];
  assign counter_clear = !cfg_out_en || out_rise;
  assign shadow_load   = out_rise || (run && frame_end);

  assign cfg_tim = '{
    h_total:     pos_t'(cfg_h_total),
    h_sync:      pos_t'(cfg_h_sync),
    h_act_start: pos_t'(cfg_h_act_start),
    h_act_end:   pos_t'(cfg_h_act_end),
    v_total:     pos_t'(cfg_v_total),
    v_sync:      pos_t'(cfg_v_sync),
    v_act_start: pos_t'(cfg_v_act_start),
    v_act_end:   pos_t'(cfg_v_act_end)
  };

  raster_shadow #(.RESET_TIM(DEF_TIM)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (shadow_load),
    .cfg_tim (cfg_tim),
    .tim     (tim_sh)
  );

  raster_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (counter_clear),
    .run       (run),
    .h_total   (tim_sh.h_total),
    .v_total   (tim_sh.v_total),
    .h_pos     (h_pos),
    .v_pos     (v_pos),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  raster_pixel #(.PIX_W(PIX_W)) u_pix (
    .run         (run),
    .pat_on      (pat_on),
    .h_pos       (h_pos),
    .v_pos       (v_pos),
    .h_sync      (tim_sh.h_sync),
    .h_act_start (tim_sh.h_act_start),
    .h_act_end   (tim_sh.h_act_end),
    .v_sync      (tim_sh.v_sync),
    .v_act_start (tim_sh.v_act_start),
    .v_act_end   (tim_sh.v_act_end),
    .pat_color   (cfg_pat_color),
    .s_data      (s_pix_data),
    .hsync       (vid_hsync),
    .vsync       (vid_vsync),
    .de          (vid_de),
    .ready       (s_pix_ready),
    .data        (vid_data)
  );
endmodule

// File: rtl/raster_video_chk.sv
module raster_video_chk #(
  parameter int PIX_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_out_en,
  input logic                run,
  input logic                pat_on,
  input logic                line_end,
  input logic                shadow_load,
  input raster_pkg::pos_t    h_pos,
  input raster_pkg::pos_t    v_pos,
  input raster_pkg::timing_t tim_sh,
  input logic                vid_hsync,
  input logic                vid_vsync,
  input logic                vid_de,
  input logic                s_pix_ready,
  input logic [PIX_W-1:0]    vid_data
);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!vid_hsync && !vid_vsync && !vid_de && !s_pix_ready));

  assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_de |-> (vid_data == '0));

  assert_ready_in_de_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_pix_ready |-> vid_de);

  assert_pattern_no_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pat_on |-> !s_pix_ready);

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end) |=> (h_pos == '0));

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg_out_en && !line_end) |=> $stable(v_pos));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_load |=> $stable(tim_sh));
endmodule

bind raster_video_gen raster_video_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_out_en  (cfg_out_en),
  .run         (run),
  .pat_on      (pat_on),
  .line_end    (line_end),
  .shadow_load (shadow_load),
  .h_pos       (h_pos),
  .v_pos       (v_pos),
  .tim_sh      (tim_sh),
  .vid_hsync   (vid_hsync),
  .vid_vsync   (vid_vsync),
  .vid_de      (vid_de),
  .s_pix_ready (s_pix_ready),
  .vid_data    (vid_data)
);

// File: tb/sim_raster_video_gen.sv
module sim_raster_video_gen;
  localparam int CNT_W = 12;
  localparam int PIX_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [CNT_W-1:0] cfg_h_total, cfg_h_sync, cfg_h_act_start, cfg_h_act_end;
  logic [CNT_W-1:0] cfg_v_total, cfg_v_sync, cfg_v_act_start, cfg_v_act_end;
  logic cfg_out_en, cfg_pat_en;
  logic [PIX_W-1:0] cfg_pat_color, s_pix_data, vid_data;
  logic s_pix_ready, vid_hsync, vid_vsync, vid_de;

  raster_video_gen #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total(cfg_h_total), .cfg_h_sync(cfg_h_sync),
    .cfg_h_act_start(cfg_h_act_start), .cfg_h_act_end(cfg_h_act_end),
    .cfg_v_total(cfg_v_total), .cfg_v_sync(cfg_v_sync),
    .cfg_v_act_start(cfg_v_act_start), .cfg_v_act_end(cfg_v_act_end),
    .cfg_out_en(cfg_out_en), .cfg_pat_en(cfg_pat_en),
    .cfg_pat_color(cfg_pat_color), .s_pix_data(s_pix_data),
    .s_pix_ready(s_pix_ready), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .vid_de(vid_de), .vid_data(vid_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  string phase_tag = "";

  // bench model: shadow timing in order
  // 0 h_total 1 h_sync 2 h_start 3 h_end 4 v_total 5 v_sync 6 v_start 7 v_end
  int sh[8];
  int mh, mv;
  bit mrun, mpat, moe_q, mpe_q;

  function automatic bit span_last(int p, int total);
    return (p + 1) >= total;
  endfunction

  function automatic bit in_span(int p, int lo, int hi);
    return (p >= lo) && (p < hi);
  endfunction

  task automatic load_shadow();
    sh[0] = cfg_h_total;     sh[1] = cfg_h_sync;
    sh[2] = cfg_h_act_start; sh[3] = cfg_h_act_end;
    sh[4] = cfg_v_total;     sh[5] = cfg_v_sync;
    sh[6] = cfg_v_act_start; sh[7] = cfg_v_act_end;
  endtask

  task automatic model_reset();
    sh = '{2200, 44, 192, 2112, 1125, 5, 41, 1121};
    mh = 0; mv = 0; mrun = 0; mpat = 0; moe_q = 1; mpe_q = 1;
  endtask

  task automatic check(string req, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s%s at cycle %0d: actual %0h expected %0h",
               phase_tag, req, cyc, act, exp);
    end
  endtask

  task automatic model_edge();
    bit rise_o, rise_p, fend;
    rise_o = cfg_out_en && !moe_q;
    rise_p = cfg_pat_en && !mpe_q;
    fend   = mrun && span_last(mh, sh[0]) && span_last(mv, sh[4]);
    if (!cfg_out_en || rise_o) begin
      mh = 0; mv = 0;
    end else if (mrun) begin
      if (span_last(mh, sh[0])) begin
        mh = 0;
        mv = span_last(mv, sh[4]) ? 0 : mv + 1;
      end else mh = mh + 1;
    end
    if (rise_o || fend) load_shadow();
    if (!cfg_out_en) mrun = 0; else if (rise_o) mrun = 1;
    if (!cfg_pat_en) mpat = 0; else if (rise_p) mpat = 1;
    moe_q = cfg_out_en;
    mpe_q = cfg_pat_en;
  endtask

  // called at a negedge with inputs set; compares, then crosses one posedge
  task automatic cycle();
    bit ede;
    logic [PIX_W-1:0] edata;
    #1;
    ede = mrun && in_span(mh, sh[2], sh[3]) && in_span(mv, sh[6], sh[7]);
    edata = !ede ? '0 : (mpat ? cfg_pat_color : s_pix_data);
    check("R2 hsync", PIX_W'(vid_hsync), PIX_W'(mrun && (mh < sh[1])));
    check("R4 vsync", PIX_W'(vid_vsync), PIX_W'(mrun && (mv < sh[5])));
    check("R3 R5 de", PIX_W'(vid_de), PIX_W'(ede));
    check(!ede ? "R9 data" : (mpat ? "R7 data" : "R8 data"), vid_data, edata);
    check("R8 ready", PIX_W'(s_pix_ready), PIX_W'(ede && !mpat));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic run_cycles(int n, bit rnd_pat);
    for (int i = 0; i < n; i++) begin
      s_pix_data = PIX_W'($urandom);
      if ($urandom_range(0, 15) == 0) cfg_pat_color = PIX_W'($urandom);
      if (rnd_pat && $urandom_range(0, 39) == 0) cfg_pat_en = ~cfg_pat_en;
      cycle();
    end
  endtask

  task automatic set_cfg(int ht, int hs, int hb, int he, int vt, int vs, int vb, int ve);
    cfg_h_total = CNT_W'(ht); cfg_h_sync = CNT_W'(hs);
    cfg_h_act_start = CNT_W'(hb); cfg_h_act_end = CNT_W'(he);
    cfg_v_total = CNT_W'(vt); cfg_v_sync = CNT_W'(vs);
    cfg_v_act_start = CNT_W'(vb); cfg_v_act_end = CNT_W'(ve);
  endtask

  task automatic random_cfg();
    int ht, hs, hb, he, vt, vs, vb, ve;
    ht = $urandom_range(8, 24);
    hs = $urandom_range(1, 3);
    hb = $urandom_range(hs, hs + 3);
    he = $urandom_range(hb + 1, ht);
    vt = $urandom_range(5, 12);
    vs = $urandom_range(1, 2);
    vb = $urandom_range(vs, vs + 2);
    ve = $urandom_range(vb + 1, vt);
    set_cfg(ht, hs, hb, he, vt, vs, vb, ve);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog R1-all: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    set_cfg(16, 3, 5, 13, 8, 2, 3, 7);
    cfg_out_en = 1'b1;   // held high through reset
    cfg_pat_en = 1'b0;
    cfg_pat_color = 16'h8010;
    s_pix_data = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 hsync", PIX_W'(vid_hsync), '0);
    check("R1 de", PIX_W'(vid_de), '0);
    check("R1 data", vid_data, '0);
    check("R1 ready", PIX_W'(s_pix_ready), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: level held from reset must not start the raster
    phase_tag = "R6/";
    run_cycles(40, 0);
    check("R6 no start", PIX_W'(vid_hsync | vid_vsync | vid_de), '0);

    // R6: a real rising change starts at (0,0): both syncs high in first cycle
    cfg_out_en = 1'b0;
    cycle();
    cfg_out_en = 1'b1;
    cycle();
    #1;
    check("R6 start sync", PIX_W'({vid_hsync, vid_vsync}), PIX_W'(2'b11));
    phase_tag = "";
    run_cycles(2 * 16 * 8, 0);

    // R7: test colour on, then off
    cfg_pat_en = 1'b1;
    run_cycles(16 * 8, 0);
    cfg_pat_en = 1'b0;
    run_cycles(40, 0);

    // R10: new timing mid-frame; old timing must finish the frame
    for (int k = 0; k < 6; k++) begin
      run_cycles($urandom_range(5, 60), 1);
      phase_tag = "R10/";
      random_cfg();
      run_cycles(3 * 24 * 12, 1);
      phase_tag = "";
    end

    // boundary setup: no sync pulses, windows over the whole line and frame
    phase_tag = "R3/";
    set_cfg(9, 0, 0, 9, 5, 0, 0, 5);
    run_cycles(2 * 16 * 8, 0);
    run_cycles(3 * 9 * 5, 1);
    phase_tag = "";

    // R6: dropping the enable idles everything at the next clock
    cfg_out_en = 1'b0;
    cycle();
    #1;
    check("R6 stop", PIX_W'({vid_hsync, vid_vsync, vid_de, s_pix_ready}), '0);
    check("R6 stop data", vid_data, '0);
    run_cycles(20, 0);

    done = 1;
    finish_run();
  end
endmodule